// File: doc/BRIEF.md
# Memory Clock and Reset Bring-up Sequencer

This block is a hardware state machine that powers up the clock and reset domains of a DRAM controller, so that boot firmware does not have to. A one-cycle start pulse launches a fixed program. The program first shuts every related domain down: it gates the clocks, disables both memory PLLs and holds the resets. It then programs the memory PLL and waits for the PLL's self-clearing update flag to drop. Next it switches the controller clock source to that PLL and waits for the source update flag to drop. Finally it releases resets and opens clock gates in a set order, turns on the controller-internal clock and waits for the controller's readiness word.

All register traffic goes through one master port, and that port carries one transaction at a time. A transaction is offered with `bus_req` together with address, write strobe and write data. It completes in the first cycle in which `bus_ready` is also high, and for a read `bus_rdata` must be valid in that cycle. While `bus_ready` is low the target applies back-pressure, and the sequencer holds every request field unchanged. Single-bit updates are done as read-modify-write pairs.

Each poll has a miss budget, set by `poll_limit`. If a poll uses up its budget, the sequencer stops, raises `error` and reports the step number on `err_step`.

Top module: `memclk_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_req` are low, and no transaction is issued until `start` is seen.
- R2: Shutdown runs as read-modify-write pairs, each clearing one bit, in this order. Bit 31 of 0x10 (interconnect clock enable). Bit 14 of 0x20 (DRAM bus clock gate). Bit 31 of 0x30 (auxiliary PLL enable). Bit 31 of 0x34 (memory PLL enable). Bit 31 of 0x14 (interconnect reset release). Bit 14 of 0x24 (DRAM bus reset release). Bit 31 of 0x40 (controller reset release).
- R3: A read-modify-write step is a read of the address followed by a write to the same address. The write data equals the read data with only the step's bit changed. No other transaction comes between the two, and only one transaction is ever outstanding.
- R4: The memory PLL at 0x34 is programmed by one write of enable (bit 31), update (bit 30) and N-1 in bits 13:8. With the default N of 46 this word is 0xC0002D00. The sequencer then reads 0x34 until bit 30 reads zero.
- R5: The controller configuration at 0x40 is then written as 0x00110000. This sets the PLL source select (bit 20) and update (bit 16), with a zero divider. The sequencer then reads 0x40 until bit 16 reads zero.
- R6: Bring-up sets bits by read-modify-write in this order. Bit 31 of 0x14. Bit 31 of 0x10. Bit 14 of 0x24. Bit 14 of 0x20. Bit 31 of 0x40. Each domain's reset is released before its clock is enabled, and the controller reset comes last.
- R7: The sequencer then writes 0x0000C00E to 0x50 and reads 0x54 until it is nonzero. After that `done` rises and `busy` falls.
- R8: If a poll reads its flag still pending `poll_limit` times in a row (once when `poll_limit` is 0), the sequencer stops with `error` high. `err_step` then holds the step number: 8 for the PLL poll, 10 for the source poll and 17 for the readiness poll. No further transactions follow.
- R9: `done` and `error` are never high together. Each stays high until the next accepted `start`, which clears it. A `start` while `busy` is ignored.
- R10: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_wr`, `bus_addr` and `bus_wdata` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; ignored while busy |
| poll_limit | input | TO_W | Pending reads allowed per poll before error |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed (sticky until next start) |
| error | output | 1 | Poll timed out (sticky until next start) |
| err_step | output | STEP_W | Step number of the timed-out poll |
| bus_req | output | 1 | Transaction request (valid) |
| bus_wr | output | 1 | Write strobe; low means read |
| bus_addr | output | RA_W | Register address |
| bus_wdata | output | RD_W | Write data |
| bus_ready | input | 1 | Target accepts the transaction this cycle |
| bus_rdata | input | RD_W | Read data, valid with bus_ready on reads |

## Verification
The bench models the target registers, including update flags that clear on their own after a chosen number of reads and a readiness word that turns nonzero late. It compares every transaction against an expected list built from the requirements. That list would catch a swapped reset/gate order, a write that clobbers neighbouring bits, or a PLL word with N instead of N-1. Random back-pressure exposes a master that changes its address or data before acceptance, or that slips a transaction between the halves of a read-modify-write. Timeouts are forced on each of the three polls, with a limit of zero among them, so the bench catches an off-by-one in the miss budget, a wrong step number, or traffic that goes on after the error. A second start while running, and a restart after an error, catch a sequencer that restarts mid-stream or leaves a stale flag set.

// File: rtl/mcrs_pkg.sv
package mcrs_pkg;

  localparam int unsigned RA_W = 8;
  localparam int unsigned RD_W = 32;

  localparam logic [RA_W-1:0] A_ICN_CLK  = 8'h10;
  localparam logic [RA_W-1:0] A_ICN_RST  = 8'h14;
  localparam logic [RA_W-1:0] A_BUS_GATE = 8'h20;
  localparam logic [RA_W-1:0] A_BUS_RST  = 8'h24;
  localparam logic [RA_W-1:0] A_PLL_AUX  = 8'h30;
  localparam logic [RA_W-1:0] A_PLL_MEM  = 8'h34;
  localparam logic [RA_W-1:0] A_CTL_CFG  = 8'h40;
  localparam logic [RA_W-1:0] A_CTL_ICLK = 8'h50;
  localparam logic [RA_W-1:0] A_CTL_RDY  = 8'h54;

  localparam logic [RD_W-1:0] M_TOP      = 32'h8000_0000;
  localparam logic [RD_W-1:0] M_DRAM_BUS = 32'h0000_4000;
  localparam logic [RD_W-1:0] M_PLL_UPD  = 32'h4000_0000;
  localparam logic [RD_W-1:0] M_CFG_SRC  = 32'h0010_0000;
  localparam logic [RD_W-1:0] M_CFG_UPD  = 32'h0001_0000;
  localparam logic [RD_W-1:0] ICLK_WORD  = 32'h0000_C00E;

  localparam int unsigned NUM_STEPS = 18;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    OP_CLR,       // read, clear mask bits, write back
    OP_SET,       // read, set mask bits, write back
    OP_WR,        // plain write of val
    OP_POLL_LOW,  // read until (data & val) == 0
    OP_POLL_ANY   // read until data != 0
  } op_e;

  typedef struct packed {
    op_e             kind;
    logic [RA_W-1:0] addr;
    logic [RD_W-1:0] val;
  } step_t;

endpackage

// File: rtl/mcrs_step_rom.sv
module mcrs_step_rom
  import mcrs_pkg::*;
#(
  parameter int unsigned PLL_N = 46
) (
  input  logic [STEP_W-1:0] idx,
  output step_t             step,
  output logic              last
);

  localparam logic [5:0]      N_FIELD  = 6'(PLL_N - 1);
  localparam logic [RD_W-1:0] PLL_WORD = M_TOP | M_PLL_UPD | {18'b0, N_FIELD, 8'b0};
  localparam logic [RD_W-1:0] CFG_WORD = M_CFG_SRC | M_CFG_UPD;

  always_comb begin
    unique case (idx)
      // shutdown: clocks off first, then resets held
      5'd0:  step = '{kind: OP_CLR, addr: A_ICN_CLK,  val: M_TOP};
      5'd1:  step = '{kind: OP_CLR, addr: A_BUS_GATE, val: M_DRAM_BUS};
      5'd2:  step = '{kind: OP_CLR, addr: A_PLL_AUX,  val: M_TOP};
      5'd3:  step = '{kind: OP_CLR, addr: A_PLL_MEM,  val: M_TOP};
      5'd4:  step = '{kind: OP_CLR, addr: A_ICN_RST,  val: M_TOP};
      5'd5:  step = '{kind: OP_CLR, addr: A_BUS_RST,  val: M_DRAM_BUS};
      5'd6:  step = '{kind: OP_CLR, addr: A_CTL_CFG,  val: M_TOP};
      // PLL programming and source switch, each with a self-clearing flag
      5'd7:  step = '{kind: OP_WR,       addr: A_PLL_MEM, val: PLL_WORD};
      5'd8:  step = '{kind: OP_POLL_LOW, addr: A_PLL_MEM, val: M_PLL_UPD};
      5'd9:  step = '{kind: OP_WR,       addr: A_CTL_CFG, val: CFG_WORD};
      5'd10: step = '{kind: OP_POLL_LOW, addr: A_CTL_CFG, val: M_CFG_UPD};
      // bring-up: reset release before clock ungate per domain
      5'd11: step = '{kind: OP_SET, addr: A_ICN_RST,  val: M_TOP};
      5'd12: step = '{kind: OP_SET, addr: A_ICN_CLK,  val: M_TOP};
      5'd13: step = '{kind: OP_SET, addr: A_BUS_RST,  val: M_DRAM_BUS};
      5'd14: step = '{kind: OP_SET, addr: A_BUS_GATE, val: M_DRAM_BUS};
      5'd15: step = '{kind: OP_SET, addr: A_CTL_CFG,  val: M_TOP};
      5'd16: step = '{kind: OP_WR,  addr: A_CTL_ICLK, val: ICLK_WORD};
      default: step = '{kind: OP_POLL_ANY, addr: A_CTL_RDY, val: '0};
    endcase
  end

  assign last = (idx == STEP_W'(NUM_STEPS - 1));

endmodule

// File: rtl/mcrs_bus_master.sv
module mcrs_bus_master
  import mcrs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  step_t           cmd,
  output logic            op_done,
  output logic [RD_W-1:0] op_rdata,
  output logic            bus_req,
  output logic            bus_wr,
  output logic [RA_W-1:0] bus_addr,
  output logic [RD_W-1:0] bus_wdata,
  input  logic            bus_ready,
  input  logic [RD_W-1:0] bus_rdata
);

  typedef enum logic [1:0] {B_IDLE, B_RD, B_WR} bst_e;

  bst_e            st_q;
  op_e             kind_q;
  logic [RA_W-1:0] addr_q;
  logic [RD_W-1:0] mask_q;
  logic [RD_W-1:0] wdata_q;

  assign bus_req   = (st_q != B_IDLE);
  assign bus_wr    = (st_q == B_WR);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= B_IDLE;
      kind_q   <= OP_CLR;
      addr_q   <= '0;
      mask_q   <= '0;
      wdata_q  <= '0;
      op_done  <= 1'b0;
      op_rdata <= '0;
    end else begin
      op_done <= 1'b0;
      unique case (st_q)
        B_IDLE: if (go) begin
          kind_q <= cmd.kind;
          addr_q <= cmd.addr;
          mask_q <= cmd.val;
          if (cmd.kind == OP_WR) begin
            wdata_q <= cmd.val;
            st_q    <= B_WR;
          end else begin
            st_q    <= B_RD;
          end
        end
        B_RD: if (bus_ready) begin
          op_rdata <= bus_rdata;
          if (kind_q == OP_CLR) begin
            wdata_q <= bus_rdata & ~mask_q;
            st_q    <= B_WR;
          end else if (kind_q == OP_SET) begin
            wdata_q <= bus_rdata | mask_q;
            st_q    <= B_WR;
          end else begin
            op_done <= 1'b1;
            st_q    <= B_IDLE;
          end
        end
        B_WR: if (bus_ready) begin
          op_done <= 1'b1;
          st_q    <= B_IDLE;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_rmw_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && !bus_wr && (kind_q == OP_CLR || kind_q == OP_SET))
      |=> (bus_req && bus_wr && $stable(bus_addr)));

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && st_q == B_IDLE) |=> !op_done);

endmodule

// File: rtl/mcrs_poll_timer.sv
module mcrs_poll_timer #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            miss,
  input  logic [TO_W-1:0] limit,
  output logic            at_limit
);

  logic [TO_W-1:0] cnt_q;

  // the current miss is the last allowed one when cnt+1 reaches the limit
  assign at_limit = ({1'b0, cnt_q} + (TO_W+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (miss)  cnt_q <= cnt_q + TO_W'(1);
  end

  assert_miss_below_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !at_limit);

endmodule

// File: rtl/memclk_bringup_seq.sv
module memclk_bringup_seq
  import mcrs_pkg::*;
#(
  parameter int unsigned PLL_N = 46,
  parameter int unsigned TO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TO_W-1:0]   poll_limit,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [STEP_W-1:0] err_step,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [RA_W-1:0]   bus_addr,
  output logic [RD_W-1:0]   bus_wdata,
  input  logic              bus_ready,
  input  logic [RD_W-1:0]   bus_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} sst_e;

  sst_e              st_q;
  logic [STEP_W-1:0] step_q;
  step_t             cur;
  logic              cur_last;
  logic              op_done;
  logic [RD_W-1:0]   op_rdata;
  logic              pass;
  logic              at_limit;
  logic              t_clr;
  logic              t_miss;

  mcrs_step_rom #(.PLL_N(PLL_N)) u_rom (
    .idx  (step_q),
    .step (cur),
    .last (cur_last)
  );

  mcrs_bus_master u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (st_q == S_ISSUE),
    .cmd       (cur),
    .op_done   (op_done),
    .op_rdata  (op_rdata),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    unique case (cur.kind)
      OP_POLL_LOW: pass = ((op_rdata & cur.val) == '0);
      OP_POLL_ANY: pass = (op_rdata != '0);
      default:     pass = 1'b1;
    endcase
  end

  assign t_miss = (st_q == S_WAIT) && op_done && !pass && !at_limit;
  assign t_clr  = ((st_q == S_IDLE) && start) ||
                  ((st_q == S_WAIT) && op_done && (pass || at_limit));

  mcrs_poll_timer #(.TO_W(TO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (t_clr),
    .miss     (t_miss),
    .limit    (poll_limit),
    .at_limit (at_limit)
  );

  assign busy = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      step_q   <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      err_step <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          step_q <= '0;
          done   <= 1'b0;
          error  <= 1'b0;
          st_q   <= S_ISSUE;
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: if (op_done) begin
          if (!pass) begin
            if (at_limit) begin
              error    <= 1'b1;
              err_step <= step_q;
              st_q     <= S_IDLE;
            end else begin
              st_q <= S_ISSUE;
            end
          end else if (cur_last) begin
            done <= 1'b1;
            st_q <= S_IDLE;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st_q   <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_error_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !bus_req);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(step_q) || busy);

endmodule

// File: tb/sim_memclk_bringup_seq.sv
module sim_memclk_bringup_seq;

  localparam logic [7:0]  X_ICN_CLK = 8'h10, X_ICN_RST = 8'h14, X_BUS_GATE = 8'h20,
                          X_BUS_RST = 8'h24, X_PLL_AUX = 8'h30, X_PLL_MEM  = 8'h34,
                          X_CFG     = 8'h40, X_ICLK    = 8'h50, X_RDY      = 8'h54;
  localparam logic [31:0] B31 = 32'h8000_0000, B30 = 32'h4000_0000, B14 = 32'h0000_4000,
                          B16 = 32'h0001_0000;
  localparam logic [31:0] INIT_VAL = 32'h9234_4121;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] poll_limit = 16'd50;
  logic        busy, done, error;
  logic [4:0]  err_step;
  logic        bus_req, bus_wr, bus_ready;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  memclk_bringup_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
    .busy(busy), .done(done), .error(error), .err_step(err_step),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // ---------------- target register model ----------------
  logic [31:0] regs [0:31];
  int pll_busy = 0, cfg_busy = 0, rdy_busy = 0;
  int pll_left = 0, cfg_left = 0, rdy_left = 0;
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  wire  [4:0] ridx = bus_addr[6:2];

  always_comb bus_ready = stall_en ? lfsr[0] : 1'b1;

  always_comb begin
    if (bus_addr == X_RDY)          bus_rdata = (rdy_left == 0) ? 32'h1 : 32'h0;
    else if (bus_addr == X_PLL_MEM) bus_rdata = (pll_left == 0) ? (regs[ridx] & ~B30) : regs[ridx];
    else if (bus_addr == X_CFG)     bus_rdata = (cfg_left == 0) ? (regs[ridx] & ~B16) : regs[ridx];
    else                            bus_rdata = regs[ridx];
  end

  logic        lg_wr   [0:255];
  logic [7:0]  lg_addr [0:255];
  logic [31:0] lg_data [0:255];
  int          lg_n = 0;
  int          hold_viol = 0;
  int          stall_seen = 0;
  logic        p_req = 1'b0, p_rdy = 1'b1, p_wr = 1'b0;
  logic [7:0]  p_addr = '0;
  logic [31:0] p_wdata = '0;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n && p_req && !p_rdy) begin
      stall_seen <= stall_seen + 1;
      if (!(bus_req && bus_wr == p_wr && bus_addr == p_addr && bus_wdata == p_wdata))
        hold_viol <= hold_viol + 1;
    end
    p_req <= bus_req; p_rdy <= bus_ready; p_wr <= bus_wr;
    p_addr <= bus_addr; p_wdata <= bus_wdata;
    if (bus_req && bus_ready) begin
      if (lg_n < 256) begin
        lg_wr[lg_n]   <= bus_wr;
        lg_addr[lg_n] <= bus_addr;
        lg_data[lg_n] <= bus_wr ? bus_wdata : bus_rdata;
      end
      lg_n <= lg_n + 1;
      if (bus_wr) begin
        regs[ridx] <= bus_wdata;
        if (bus_addr == X_PLL_MEM && bus_wdata[30]) pll_left <= pll_busy;
        if (bus_addr == X_CFG && bus_wdata[16])     cfg_left <= cfg_busy;
        if (bus_addr == X_ICLK)                     rdy_left <= rdy_busy;
      end else begin
        if (bus_addr == X_PLL_MEM && pll_left != 0) pll_left <= pll_left - 1;
        if (bus_addr == X_CFG && cfg_left != 0)     cfg_left <= cfg_left - 1;
        if (bus_addr == X_RDY && rdy_left != 0)     rdy_left <= rdy_left - 1;
      end
    end
  end

  // ---------------- expected transaction list ----------------
  logic        e_wr   [0:255];
  logic [7:0]  e_addr [0:255];
  logic [31:0] e_data [0:255];
  logic        e_dc   [0:255];
  string       e_tag  [0:255];
  int          e_n;
  logic [31:0] sh [0:31];

  task automatic add_e(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic dc, input string t);
    e_wr[e_n] = w; e_addr[e_n] = a; e_data[e_n] = d; e_dc[e_n] = dc; e_tag[e_n] = t;
    e_n++;
  endtask

  task automatic rmw_e(input logic [7:0] a, input logic [31:0] m, input logic set, input string t);
    logic [31:0] v;
    v = set ? (sh[a[6:2]] | m) : (sh[a[6:2]] & ~m);
    add_e(1'b0, a, sh[a[6:2]], 1'b1, t);
    add_e(1'b1, a, v, 1'b1, t);
    sh[a[6:2]] = v;
  endtask

  task automatic poll_e(input logic [7:0] a, input int n, input string t);
    for (int i = 0; i < n; i++) add_e(1'b0, a, 32'h0, 1'b0, t);
  endtask

  task automatic build(input int pp, input int cp, input int rp);
    for (int i = 0; i < 32; i++) sh[i] = INIT_VAL;
    sh[X_PLL_MEM[6:2]] = INIT_VAL & ~B30;
    sh[X_CFG[6:2]]     = INIT_VAL & ~B16;
    e_n = 0;
    rmw_e(X_ICN_CLK, B31, 1'b0, "R2");
    rmw_e(X_BUS_GATE, B14, 1'b0, "R2");
    rmw_e(X_PLL_AUX, B31, 1'b0, "R2");
    rmw_e(X_PLL_MEM, B31, 1'b0, "R2");
    rmw_e(X_ICN_RST, B31, 1'b0, "R2");
    rmw_e(X_BUS_RST, B14, 1'b0, "R2");
    rmw_e(X_CFG, B31, 1'b0, "R2");
    add_e(1'b1, X_PLL_MEM, 32'hC000_2D00, 1'b1, "R4");
    poll_e(X_PLL_MEM, pp + 1, "R4");
    add_e(1'b1, X_CFG, 32'h0011_0000, 1'b1, "R5");
    poll_e(X_CFG, cp + 1, "R5");
    sh[X_CFG[6:2]] = 32'h0010_0000;
    rmw_e(X_ICN_RST, B31, 1'b1, "R6");
    rmw_e(X_ICN_CLK, B31, 1'b1, "R6");
    rmw_e(X_BUS_RST, B14, 1'b1, "R6");
    rmw_e(X_BUS_GATE, B14, 1'b1, "R6");
    rmw_e(X_CFG, B31, 1'b1, "R6");
    add_e(1'b1, X_ICLK, 32'h0000_C00E, 1'b1, "R7");
    poll_e(X_RDY, rp + 1, "R7");
  endtask

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic prep(input int pp, input int cp, input int rp);
    for (int i = 0; i < 32; i++) regs[i] = INIT_VAL;
    pll_left = 0; cfg_left = 0; rdy_left = 0;
    pll_busy = pp; cfg_busy = cp; rdy_busy = rp;
    lg_n = 0;
  endtask

  task automatic launch();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || error) break;
    end
  endtask

  task automatic compare_log();
    chk("R3", "transaction count", 32'(lg_n), 32'(e_n));
    for (int i = 0; i < e_n && i < lg_n; i++) begin
      chk(e_tag[i], $sformatf("txn %0d write strobe", i), 32'(lg_wr[i]), 32'(e_wr[i]));
      chk(e_tag[i], $sformatf("txn %0d address", i), 32'(lg_addr[i]), 32'(e_addr[i]));
      if (e_dc[i]) chk(e_tag[i], $sformatf("txn %0d data", i), lg_data[i], e_data[i]);
    end
  endtask

  function automatic int count_reads(input logic [7:0] a);
    int c = 0;
    for (int i = 0; i < lg_n && i < 256; i++) if (!lg_wr[i] && lg_addr[i] == a) c++;
    return c;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "bus_req in reset", 32'(bus_req), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", "done after reset", 32'(done), 0);
    chk("R1", "error after reset", 32'(error), 0);
    chk("R1", "busy idle", 32'(busy), 0);
    chk("R1", "no traffic without start", 32'(lg_n), 0);
  endtask

  task automatic t_nominal();
    poll_limit = 16'd50;
    prep(2, 1, 3); build(2, 1, 3);
    launch(); wait_end();
    chk("R7", "done after full run", 32'(done), 1);
    chk("R7", "busy after done", 32'(busy), 0);
    chk("R8", "no error on nominal run", 32'(error), 0);
    compare_log();
  endtask

  task automatic t_backpressure();
    poll_limit = 16'd50;
    stall_en = 1'b1;
    prep(0, 0, 0); build(0, 0, 0);
    launch(); wait_end();
    stall_en = 1'b0;
    chk("R7", "done under stalls", 32'(done), 1);
    compare_log();
    chk("R10", "fields held while stalled", 32'(hold_viol), 0);
    chk("R10", "stalls occurred", 32'(stall_seen > 0), 1);
  endtask

  task automatic t_sticky();
    int n0;
    n0 = lg_n;
    repeat (25) @(negedge clk);
    chk("R9", "done stays high", 32'(done), 1);
    chk("R9", "no traffic after done", 32'(lg_n), 32'(n0));
  endtask

  task automatic t_start_while_busy();
    poll_limit = 16'd50;
    prep(1, 1, 1); build(1, 1, 1);
    launch();
    chk("R9", "done cleared by start", 32'(done), 0);
    repeat (8) @(negedge clk);
    launch();
    wait_end();
    chk("R9", "single sequence despite second start", 32'(lg_n), 32'(e_n));
    compare_log();
  endtask

  task automatic t_timeout_ready();
    int n0;
    poll_limit = 16'd4;
    prep(0, 0, 1000);
    launch(); wait_end();
    chk("R8", "error on ready timeout", 32'(error), 1);
    chk("R8", "done low on error", 32'(done), 0);
    chk("R8", "err_step for ready poll", 32'(err_step), 17);
    chk("R8", "ready reads before error", 32'(count_reads(X_RDY)), 4);
    n0 = lg_n;
    repeat (30) @(negedge clk);
    chk("R8", "silent after error", 32'(lg_n), 32'(n0));
    chk("R9", "error stays high", 32'(error), 1);
  endtask

  task automatic t_timeout_pll();
    poll_limit = 16'd3;
    prep(1000, 0, 0);
    launch(); wait_end();
    chk("R8", "error on PLL timeout", 32'(error), 1);
    chk("R8", "err_step for PLL poll", 32'(err_step), 8);
    chk("R8", "PLL poll reads (plus one shutdown read)", 32'(count_reads(X_PLL_MEM)), 4);
  endtask

  task automatic t_timeout_zero();
    poll_limit = 16'd0;
    prep(0, 5, 0);
    launch(); wait_end();
    chk("R8", "error with zero limit", 32'(error), 1);
    chk("R8", "err_step for source poll", 32'(err_step), 10);
    chk("R8", "source poll reads (plus one shutdown read)", 32'(count_reads(X_CFG)), 2);
  endtask

  task automatic t_restart_after_error();
    poll_limit = 16'd50;
    prep(0, 2, 0); build(0, 2, 0);
    launch();
    @(negedge clk);
    chk("R9", "error cleared by start", 32'(error), 0);
    chk("R9", "busy after start", 32'(busy), 1);
    wait_end();
    chk("R9", "done after restart", 32'(done), 1);
    compare_log();
  endtask

  // ---------------- control ----------------
  initial begin
    for (int i = 0; i < 32; i++) regs[i] = INIT_VAL;
    repeat (3) @(negedge clk);
    t_reset();
    t_nominal();
    t_sticky();
    t_backpressure();
    t_start_while_busy();
    t_timeout_ready();
    t_timeout_pll();
    t_timeout_zero();
    t_restart_after_error();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule